// File: doc/BRIEF.md
# Oblivious Banked Candidate Table

This block stores the eight precomputed point multiples used by a generic scalar multiplier. Each candidate lives in its own on-chip RAM bank as forty 32-bit words. A write port fills the candidates one word at a time as the point arithmetic produces them.

A read port takes a public word address and a secret window digit. Every lookup reads that one word from all eight banks at the same address in the same cycle. The digit is applied only after the read, through a one-hot decoded AND-mask and OR-reduction. Bank enables, addresses and timing are therefore the same for every digit value.

Two saturating counters report the accepted writes and the logical candidate-word reads, where each lookup word counts as one read per bank. A start pulse clears both counters. One full scalar multiplication fills 320 words and performs 64 lookups of 40 words each, so it must leave the counters at 320 and 20,480 whatever the scalar was. All of this traffic is local RAM traffic and never reaches external memory.

Top module: `cand_table`

## Requirements
- R1: After reset, `rd_valid_o` is 0, `rd_data_o` is 0, and both counters read 0.
- R2: A write with `wr_en_i`=1, bank `wr_bank_i` (0..7) and word `wr_addr_i` below 40 stores `wr_data_i` in that word of that bank and raises `wr_count_o` by one.
- R3: A write whose word address is 40 or more is dropped: no word changes and `wr_count_o` stays the same.
- R4: A read request (`rd_en_i`=1, word address, digit `rd_sel_i` in 0..7) gives `rd_valid_o`=1 and `rd_data_o` equal to that word of bank `rd_sel_i` exactly one cycle later. Back-to-back requests stream one word per cycle.
- R5: While `rd_valid_o` is 0, `rd_data_o` is all zeros.
- R6: Every read request enables all eight banks at the one requested address and raises `rd_count_o` by 8, whatever the digit. A 40-word lookup gives exactly 40 consecutive valid cycles for every digit.
- R7: After a start pulse, filling all 320 words and then running 64 lookups of words 0..39 leaves `wr_count_o`=320 and `rd_count_o`=20480.
- R8: A start pulse (`start_i`=1) clears both counters on the next edge and takes priority over a write or read counted in the same cycle.
- R9: A read and a write to the same bank and word in the same cycle return the word's old contents. The new contents are returned from the next cycle on.
- R10: The counters saturate at all-ones (width `CNT_W`) and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears both counters |
| wr_en_i | input | 1 | Write strobe |
| wr_bank_i | input | 3 | Bank (candidate) to write |
| wr_addr_i | input | 6 | Word index within the candidate |
| wr_data_i | input | 32 | Word to store |
| rd_en_i | input | 1 | Lookup word request |
| rd_addr_i | input | 6 | Public word index, sent to every bank |
| rd_sel_i | input | 3 | Secret digit choosing the candidate |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 32 | Selected candidate word |
| wr_count_o | output | CNT_W | Accepted writes, saturating |
| rd_count_o | output | CNT_W | Logical bank-word reads, saturating |

## Verification
A corrupted bank word or a stale registered digit shows up on `rd_data_o` one cycle after the read that touches it. Every candidate word is read back under a known pattern, so such a fault shows on the first affected lookup. A counter that skips, double counts or ignores the start pulse drifts away from the per-lookup totals of multiples of 320. The bench checks these totals after each lookup. A second instance with narrow counters shows the saturation of the read counter within the same run.

// File: rtl/cand_table_pkg.sv
package cand_table_pkg;
  localparam int unsigned CT_BANKS = 8;
  localparam int unsigned CT_WORDS = 40;
  localparam int unsigned CT_DW    = 32;
  localparam int unsigned CT_CW    = 32;
endpackage

// File: rtl/cand_bank.sv
module cand_bank #(
  parameter int unsigned WORDS = cand_table_pkg::CT_WORDS,
  parameter int unsigned DW    = cand_table_pkg::CT_DW,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  // read-first: a read sees the contents before a same-cycle write
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= (32'(raddr_i) < WORDS) ? mem[raddr_i] : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cand_mux.sv
module cand_mux #(
  parameter int unsigned NB  = cand_table_pkg::CT_BANKS,
  parameter int unsigned DW  = cand_table_pkg::CT_DW,
  localparam int unsigned BW = $clog2(NB)
) (
  input  logic [NB-1:0][DW-1:0] words_i,
  input  logic [BW-1:0]         sel_i,
  input  logic                  en_i,
  output logic [DW-1:0]         word_o
);
  logic [NB-1:0] onehot;

  always_comb begin
    for (int i = 0; i < NB; i++) onehot[i] = en_i & (sel_i == BW'(i));
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NB; i++) word_o = word_o | (words_i[i] & {DW{onehot[i]}});
  end
endmodule

// File: rtl/cand_counter.sv
module cand_counter #(
  parameter int unsigned CW = cand_table_pkg::CT_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] step_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] count_q, count_d;
  logic [CW:0]   sum;

  always_comb begin
    sum = {1'b0, count_q} + {1'b0, step_i};
    count_d = count_q;
    if (clr_i)      count_d = '0;
    else if (inc_i) count_d = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0)); // R8
  AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (&count_o)) |=> (&count_o)); // R10
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (count_o >= $past(count_o))); // R10
endmodule

// File: rtl/cand_table.sv
module cand_table
  import cand_table_pkg::*;
#(
  parameter int unsigned NBANK = CT_BANKS,
  parameter int unsigned WORDS = CT_WORDS,
  parameter int unsigned DW    = CT_DW,
  parameter int unsigned CNT_W = CT_CW,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_en_i,
  input  logic [BW-1:0]    wr_bank_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [BW-1:0]    rd_sel_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] wr_count_o,
  output logic [CNT_W-1:0] rd_count_o
);
  logic                  wr_ok;
  logic [NBANK-1:0]      bank_we;
  logic [NBANK-1:0]      bank_re;
  logic [NBANK-1:0][DW-1:0] bank_word;
  logic                  valid_q, valid_d;
  logic [BW-1:0]         sel_q, sel_d;

  assign wr_ok = wr_en_i && (32'(wr_addr_i) < WORDS);

  // every bank sees the same public address and the same read enable
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = wr_ok && (wr_bank_i == BW'(b));
    assign bank_re[b] = rd_en_i;
    cand_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
      .clk     (clk),
      .we_i    (bank_we[b]),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .re_i    (bank_re[b]),
      .raddr_i (rd_addr_i),
      .rdata_o (bank_word[b])
    );
  end

  always_comb begin
    valid_d = rd_en_i;
    sel_d   = rd_en_i ? rd_sel_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      valid_q <= valid_d;
      sel_q   <= sel_d;
    end
  end

  cand_mux #(.NB(NBANK), .DW(DW)) u_mux (
    .words_i (bank_word),
    .sel_i   (sel_q),
    .en_i    (valid_q),
    .word_o  (rd_data_o)
  );

  assign rd_valid_o = valid_q;

  cand_counter #(.CW(CNT_W)) u_wr_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .inc_i   (wr_ok),
    .step_i  (CNT_W'(1)),
    .count_o (wr_count_o)
  );

  cand_counter #(.CW(CNT_W)) u_rd_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .inc_i   (rd_en_i),
    .step_i  (CNT_W'(NBANK)),
    .count_o (rd_count_o)
  );

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R4
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o); // R4
  AST_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_re) == 0) || ($countones(bank_re) == NBANK)); // R6
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (32'(wr_addr_i) >= WORDS) && !start_i) |=> $stable(wr_count_o)); // R3
endmodule

// File: tb/tb_cand_table.sv
module tb_cand_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        wr_en;
  logic [2:0]  wr_bank;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [2:0]  rd_sel;
  logic        rd_valid, rd_valid_s;
  logic [31:0] rd_data, rd_data_s;
  logic [31:0] wr_cnt, rd_cnt;
  logic [11:0] wr_cnt_s, rd_cnt_s;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cand_table dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_sel_i(rd_sel),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .wr_count_o(wr_cnt), .rd_count_o(rd_cnt)
  );

  cand_table #(.CNT_W(12)) dut_s (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_sel_i(rd_sel),
    .rd_valid_o(rd_valid_s), .rd_data_o(rd_data_s),
    .wr_count_o(wr_cnt_s), .rd_count_o(rd_cnt_s)
  );

  function automatic logic [31:0] pat(input int b, input int w);
    return 32'h5A00_0000 ^ (32'(b) << 20) ^ (32'(w) * 32'h0001_0203);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; start = 0; wr_en = 0; wr_bank = 0; wr_addr = 0; wr_data = 0;
    rd_en = 0; rd_addr = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid == 0, "R1 valid", 32'(rd_valid), 0);
    chk(rd_data == 0, "R1 data", rd_data, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 counters", wr_cnt | rd_cnt, 0);
  endtask

  task automatic t_start;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(wr_cnt == 0 && rd_cnt == 0, "R8 clear", wr_cnt | rd_cnt, 0);
  endtask

  task automatic t_fill;
    for (int b = 0; b < 8; b++) begin
      for (int w = 0; w < 40; w++) begin
        wr_en = 1; wr_bank = 3'(b); wr_addr = 6'(w); wr_data = pat(b, w);
        @(negedge clk);
      end
    end
    wr_en = 0;
    chk(wr_cnt == 320, "R2 write count", wr_cnt, 320);
    chk(wr_cnt_s == 12'd320, "R2 narrow write count", 32'(wr_cnt_s), 320);
  endtask

  task automatic t_lookups;
    int ok_words;
    for (int k = 0; k < 64; k++) begin
      int d = (k * 3 + 1) % 8;
      ok_words = 0;
      for (int w = 0; w < 40; w++) begin
        rd_en = 1; rd_addr = 6'(w); rd_sel = 3'(d);
        @(negedge clk);
        if (rd_valid && rd_data == pat(d, w)) ok_words++;
        else chk(0, "R4 lookup word", rd_data, pat(d, w));
      end
      chk(ok_words == 40, "R6 constant 40 valid cycles", 32'(ok_words), 40);
      chk(rd_cnt == 32'((k + 1) * 320), "R6 read count per lookup", rd_cnt, 32'((k + 1) * 320));
    end
    rd_en = 0;
    @(negedge clk);
    chk(rd_valid == 0, "R5 valid low", 32'(rd_valid), 0);
    chk(rd_data == 0, "R5 data zero", rd_data, 0);
    chk(wr_cnt == 320, "R7 write total", wr_cnt, 320);
    chk(rd_cnt == 20480, "R7 read total", rd_cnt, 20480);
    chk(rd_cnt_s == 12'hFFF, "R10 read counter saturates", 32'(rd_cnt_s), 32'hFFF);
  endtask

  task automatic read1(input int b, input int w, output logic [31:0] v);
    rd_en = 1; rd_addr = 6'(w); rd_sel = 3'(b);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic t_drop;
    logic [31:0] v;
    wr_en = 1; wr_bank = 0; wr_addr = 6'd40; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 0;
    chk(wr_cnt == 320, "R3 dropped write not counted", wr_cnt, 320);
    read1(0, 39, v);
    chk(v == pat(0, 39), "R3 neighbour untouched", v, pat(0, 39));
  endtask

  task automatic t_rdw;
    logic [31:0] v;
    wr_en = 1; wr_bank = 3'd2; wr_addr = 6'd5; wr_data = 32'hCAFE_0005;
    rd_en = 1; rd_addr = 6'd5; rd_sel = 3'd2;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(rd_data == pat(2, 5), "R9 old word on collision", rd_data, pat(2, 5));
    read1(2, 5, v);
    chk(v == 32'hCAFE_0005, "R9 new word afterwards", v, 32'hCAFE_0005);
  endtask

  task automatic t_start_priority;
    logic [31:0] v;
    start = 1; wr_en = 1; wr_bank = 3'd7; wr_addr = 6'd0; wr_data = 32'h0BAD_F00D;
    rd_en = 1; rd_addr = 6'd1; rd_sel = 3'd3;
    @(negedge clk);
    start = 0; wr_en = 0; rd_en = 0;
    chk(wr_cnt == 0 && rd_cnt == 0, "R8 start beats increment", wr_cnt | rd_cnt, 0);
    read1(7, 0, v);
    chk(v == 32'h0BAD_F00D, "R2 write under start stored", v, 32'h0BAD_F00D);
    chk(rd_cnt == 8, "R6 single read counts 8", rd_cnt, 8);
  endtask

  initial begin
    t_reset;
    t_start;
    t_fill;
    t_lookups;
    t_drop;
    t_rdw;
    t_start_priority;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule